// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory Controller

This block keeps the coherence state of the memory blocks at one home node. Each directory entry holds a memory state (shared read-only or exclusively owned), an acknowledgement countdown, a small fixed set of sharer pointers and a meta-state. Decoded protocol packets arrive one per cycle: read requests, write requests and invalidate acknowledgements. The controller answers with data grants, write-permission grants, busy replies and invalidations, all registered one cycle after the packet.

Most blocks have only a few sharers, and the hardware handles that case on its own. If a new reader would need more pointers than exist, or a write reaches a block whose sharer list has moved into memory, the controller raises a trap request for a software handler. The handler works on the entry through a register-style port. It can read every field, clear the pointers, load the countdown together with the new owner, set the meta-state and dismiss the trap. The meta-state tells the hardware either to stand back while software moves the pointers, or to trap writes after an overflow.

Top module: `lp_dir_ctrl`

## Requirements
- R1: After reset every entry is read-only (`sw_rd_rw`=0) with meta-state Normal (0), countdown 0 and no valid pointer; `rsp_valid`, `inv_valid` and `trap_req` are 0.
- R2: A read (`req_type`=0) to a read-only entry whose countdown is 0 returns DATA (`rsp_kind`=0) to the requester on the next cycle. A requester that is not yet present takes the lowest-numbered free pointer slot. A requester already present leaves the pointers unchanged.
- R3: A read from a new requester to a read-only entry with every slot valid changes no pointer and sends no response. It raises `trap_req` with `trap_entry`, `trap_src` and `trap_write`=0. The trap stays raised and unchanged until software dismisses it.
- R4: A write (`req_type`=1) to an owned entry from a node other than the owner sends one invalidation to the owner in invalidation slot 0 and no response. The countdown becomes 1 and the requester becomes the only pointer, in slot 0.
- R5: A write to a read-only entry sends, in the same cycle, an invalidation in slot k for every valid pointer k other than the requester. The countdown is set to the number of invalidations, the entry becomes owned, and the requester becomes the only pointer. If no invalidation is needed, WPERM (`rsp_kind`=1) goes to the requester at once. A write by the current owner also gets WPERM at once.
- R6: Each acknowledgement (`req_type`=2) decrements a nonzero countdown. The one that reaches zero sends a grant to the slot-0 pointer: WPERM for a pending write, DATA for a pending read. An acknowledgement while the countdown is 0 has no effect.
- R7: A read or write to an entry with a nonzero countdown gets BUSY (`rsp_kind`=2) addressed to the requester, and the entry does not change.
- R8: While an entry's meta-state is Trans-In-Progress (1), every packet to it, acknowledgements included, gets BUSY and the entry does not change.
- R9: With meta-state Trap-On-Write (2), reads are handled as in R2. A write raises the trap with `trap_write`=1 and sends no invalidation and no response.
- R10: Software port `sw_op`: 1 clears all pointers; 2 loads the countdown from `sw_data`, makes the entry owned with `sw_id` as the only pointer and marks a write as pending; 3 sets the meta-state to `sw_data[1:0]`; 4 dismisses the trap. The read-out port reflects the entry chosen by `sw_rd_entry`.
- R11: A read to an owned entry from a non-owner invalidates the owner (slot 0) and sets the countdown to 1. When the acknowledgement arrives, DATA goes to the reader, and the entry becomes read-only with the reader as its only sharer.
- R12: A packet gets BUSY if it would need a trap while one is already raised. It also gets BUSY if it names the same entry as a software operation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Packet present |
| req_type | input | 2 | 0 read, 1 write, 2 acknowledgement |
| req_entry | input | EW | Directory entry addressed |
| req_src | input | IW | Sending node |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | 0 DATA, 1 WPERM, 2 BUSY |
| rsp_dest | output | IW | Response destination |
| inv_valid | output | P | One bit per invalidation slot |
| inv_dest | output | P*IW | Destination per invalidation slot |
| trap_req | output | 1 | Software trap raised |
| trap_entry | output | EW | Entry that trapped |
| trap_src | output | IW | Requester that caused the trap |
| trap_write | output | 1 | 1 for a write trap, 0 for a read overflow |
| sw_op | input | 3 | Software operation code (R10) |
| sw_entry | input | EW | Entry the operation acts on |
| sw_data | input | CW | Countdown value or meta-state |
| sw_id | input | IW | Owner loaded with the countdown |
| sw_rd_entry | input | EW | Entry shown on the read-out port |
| sw_rd_rw | output | 1 | 1 when owned |
| sw_rd_meta | output | 2 | Meta-state |
| sw_rd_ctr | output | CW | Acknowledgement countdown |
| sw_rd_ptr_v | output | P | Pointer valid flags |
| sw_rd_ptr_id | output | P*IW | Pointer identifiers |

## Verification
The assertions assume that packets of type 3 never arrive, that acknowledgements come only from nodes that were invalidated, and that `req_src` and `sw_op` are zero when not in use. They also assume that an owned entry always keeps its owner in pointer slot 0, so software never clears the pointers of an entry in the middle of a countdown. The stimulus keeps to these rules. It sends acknowledgements only after invalidations, and it clears pointers only on idle entries or while the meta-state keeps hardware away. A sweep fills every entry to overflow, then runs every kind of ownership change over those populated entries.

// File: rtl/lp_dir_ctrl.sv
module lp_dir_ctrl #(
  parameter int NENT = 4,
  parameter int P    = 4,
  parameter int IW   = 6,
  parameter int CW   = 7,
  localparam int EW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_type,
  input  logic [EW-1:0]   req_entry,
  input  logic [IW-1:0]   req_src,
  output logic            rsp_valid,
  output logic [1:0]      rsp_kind,
  output logic [IW-1:0]   rsp_dest,
  output logic [P-1:0]    inv_valid,
  output logic [P*IW-1:0] inv_dest,
  output logic            trap_req,
  output logic [EW-1:0]   trap_entry,
  output logic [IW-1:0]   trap_src,
  output logic            trap_write,
  input  logic [2:0]      sw_op,
  input  logic [EW-1:0]   sw_entry,
  input  logic [CW-1:0]   sw_data,
  input  logic [IW-1:0]   sw_id,
  input  logic [EW-1:0]   sw_rd_entry,
  output logic            sw_rd_rw,
  output logic [1:0]      sw_rd_meta,
  output logic [CW-1:0]   sw_rd_ctr,
  output logic [P-1:0]    sw_rd_ptr_v,
  output logic [P*IW-1:0] sw_rd_ptr_id
);
  localparam int SLW = (P > 1) ? $clog2(P) : 1;
  localparam logic [1:0] RQ_RD = 2'd0, RQ_WR = 2'd1, RQ_ACK = 2'd2;
  localparam logic [1:0] RK_DATA = 2'd0, RK_WPERM = 2'd1, RK_BUSY = 2'd2;
  localparam logic [1:0] M_TIP = 2'd1, M_TOW = 2'd2;
  localparam logic [2:0] OP_NONE = 3'd0, OP_CLR = 3'd1, OP_LOAD = 3'd2, OP_META = 3'd3, OP_ACK = 3'd4;

  logic            rw_q   [NENT];
  logic [1:0]      meta_q [NENT];
  logic [CW-1:0]   ctr_q  [NENT];
  logic            pw_q   [NENT];
  logic [P-1:0]    pv_q   [NENT];
  logic [P*IW-1:0] pid_q  [NENT];

  logic            c_rw, c_pw;
  logic [1:0]      c_meta;
  logic [CW-1:0]   c_ctr;
  logic [P-1:0]    c_pv;
  logic [P*IW-1:0] c_pid;

  assign c_rw   = rw_q[req_entry];
  assign c_pw   = pw_q[req_entry];
  assign c_meta = meta_q[req_entry];
  assign c_ctr  = ctr_q[req_entry];
  assign c_pv   = pv_q[req_entry];
  assign c_pid  = pid_q[req_entry];

  assign sw_rd_rw     = rw_q[sw_rd_entry];
  assign sw_rd_meta   = meta_q[sw_rd_entry];
  assign sw_rd_ctr    = ctr_q[sw_rd_entry];
  assign sw_rd_ptr_v  = pv_q[sw_rd_entry];
  assign sw_rd_ptr_id = pid_q[sw_rd_entry];

  logic [P-1:0]    hit, others;
  logic [SLW-1:0]  free_slot;
  logic            upd, n_rw, n_pw, o_rv, set_trap, set_trap_w;
  logic [1:0]      o_kind;
  logic [IW-1:0]   o_dest;
  logic [P-1:0]    o_inv, n_pv;
  logic [P*IW-1:0] o_invd, n_pid;
  logic [CW-1:0]   n_ctr;
  logic            conflict;

  assign conflict = (sw_op != OP_NONE) && (sw_entry == req_entry);
  assign others   = c_pv & ~hit;

  always_comb begin
    hit = '0;
    free_slot = '0;
    for (int k = P - 1; k >= 0; k--) begin
      hit[k] = c_pv[k] && (c_pid[k*IW +: IW] == req_src);
      if (!c_pv[k]) free_slot = SLW'(k);
    end
  end

  always_comb begin
    upd = 1'b0;  n_rw = c_rw;  n_pw = c_pw;  n_ctr = c_ctr;
    n_pv = c_pv; n_pid = c_pid;
    o_rv = 1'b0; o_kind = RK_DATA; o_dest = req_src;
    o_inv = '0;  o_invd = '0;
    set_trap = 1'b0; set_trap_w = 1'b0;
    if (req_valid) begin
      if (conflict || c_meta == M_TIP) begin
        o_rv = 1'b1; o_kind = RK_BUSY;
      end else if (req_type == RQ_ACK) begin
        if (c_ctr != '0) begin
          upd = 1'b1;
          n_ctr = c_ctr - 1'b1;
          if (c_ctr == CW'(1)) begin
            o_rv = 1'b1;
            o_kind = c_pw ? RK_WPERM : RK_DATA;
            o_dest = c_pid[IW-1:0];
            if (!c_pw) n_rw = 1'b0;
          end
        end
      end else if (req_type == RQ_RD || req_type == RQ_WR) begin
        if (c_ctr != '0) begin
          o_rv = 1'b1; o_kind = RK_BUSY;
        end else if (req_type == RQ_RD) begin
          if (c_rw) begin
            if (hit[0]) begin
              o_rv = 1'b1;
            end else begin
              upd = 1'b1;
              o_inv[0] = 1'b1;
              o_invd[IW-1:0] = c_pid[IW-1:0];
              n_ctr = CW'(1); n_pw = 1'b0;
              n_pv = P'(1); n_pid = '0; n_pid[IW-1:0] = req_src;
            end
          end else if (|hit) begin
            o_rv = 1'b1;
          end else if (!(&c_pv)) begin
            upd = 1'b1; o_rv = 1'b1;
            n_pv[free_slot] = 1'b1;
            n_pid[free_slot*IW +: IW] = req_src;
          end else if (trap_req) begin
            o_rv = 1'b1; o_kind = RK_BUSY;
          end else begin
            set_trap = 1'b1;
          end
        end else begin
          if (c_meta == M_TOW) begin
            if (trap_req) begin
              o_rv = 1'b1; o_kind = RK_BUSY;
            end else begin
              set_trap = 1'b1; set_trap_w = 1'b1;
            end
          end else if (c_rw && hit[0]) begin
            o_rv = 1'b1; o_kind = RK_WPERM;
          end else begin
            upd = 1'b1;
            n_rw = 1'b1; n_pw = 1'b1;
            n_pv = P'(1); n_pid = '0; n_pid[IW-1:0] = req_src;
            if (c_rw) begin
              o_inv[0] = 1'b1;
              o_invd[IW-1:0] = c_pid[IW-1:0];
              n_ctr = CW'(1);
            end else begin
              o_inv = others;
              o_invd = c_pid;
              n_ctr = CW'($countones(others));
              if (others == '0) begin
                o_rv = 1'b1; o_kind = RK_WPERM;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) begin
        rw_q[e] <= 1'b0; meta_q[e] <= '0; ctr_q[e] <= '0;
        pw_q[e] <= 1'b0; pv_q[e] <= '0;   pid_q[e] <= '0;
      end
      rsp_valid <= 1'b0; rsp_kind <= '0; rsp_dest <= '0;
      inv_valid <= '0;   inv_dest <= '0;
      trap_req <= 1'b0;  trap_entry <= '0; trap_src <= '0; trap_write <= 1'b0;
    end else begin
      rsp_valid <= o_rv; rsp_kind <= o_kind; rsp_dest <= o_dest;
      inv_valid <= o_inv; inv_dest <= o_invd;
      if (upd) begin
        rw_q[req_entry]  <= n_rw;  pw_q[req_entry]  <= n_pw;
        ctr_q[req_entry] <= n_ctr; pv_q[req_entry]  <= n_pv;
        pid_q[req_entry] <= n_pid;
      end
      if (set_trap) begin
        trap_req <= 1'b1; trap_entry <= req_entry;
        trap_src <= req_src; trap_write <= set_trap_w;
      end
      case (sw_op)
        OP_CLR:  pv_q[sw_entry] <= '0;
        OP_LOAD: begin
          ctr_q[sw_entry] <= sw_data; rw_q[sw_entry] <= 1'b1; pw_q[sw_entry] <= 1'b1;
          pv_q[sw_entry] <= P'(1);
          pid_q[sw_entry] <= {{((P-1)*IW){1'b0}}, sw_id};
        end
        OP_META: meta_q[sw_entry] <= sw_data[1:0];
        OP_ACK:  trap_req <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lp_dir_ctrl_chk.sv
module lp_dir_ctrl_chk #(
  parameter int P  = 4,
  parameter int IW = 6,
  parameter int EW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_type,
  input logic [IW-1:0]   req_src,
  input logic            rsp_valid,
  input logic [1:0]      rsp_kind,
  input logic [IW-1:0]   rsp_dest,
  input logic [P-1:0]    inv_valid,
  input logic [P*IW-1:0] inv_dest,
  input logic            trap_req,
  input logic [EW-1:0]   trap_entry,
  input logic [IW-1:0]   trap_src,
  input logic [2:0]      sw_op
);
  a_r4_inv_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_valid) |-> ($past(req_valid) && $past(req_type) != 2'd2));

  a_r4_inv_without_response: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_valid) |-> !rsp_valid);

  a_r2_response_from_packet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  a_r7_busy_to_sender: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd2) |-> rsp_dest == $past(req_src));

  a_r3_trap_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(trap_req) && $past(sw_op) != 3'd4) |->
      (trap_req && trap_entry == $past(trap_entry) && trap_src == $past(trap_src)));

  for (genvar k = 0; k < P; k++) begin : g_slot
    a_r5_no_self_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid[k] |-> inv_dest[k*IW +: IW] != $past(req_src));
  end
endmodule

bind lp_dir_ctrl lp_dir_ctrl_chk #(.P(P), .IW(IW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
  .req_src(req_src), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
  .rsp_dest(rsp_dest), .inv_valid(inv_valid), .inv_dest(inv_dest),
  .trap_req(trap_req), .trap_entry(trap_entry), .trap_src(trap_src),
  .sw_op(sw_op)
);

// File: tb/lp_dir_ctrl_bench.sv
`timescale 1ns/1ps
module lp_dir_ctrl_bench;
  localparam int NENT = 4, P = 4, IW = 6, CW = 7, EW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_type = '0;
  logic [EW-1:0] req_entry = '0;
  logic [IW-1:0] req_src = '0;
  logic rsp_valid; logic [1:0] rsp_kind; logic [IW-1:0] rsp_dest;
  logic [P-1:0] inv_valid; logic [P*IW-1:0] inv_dest;
  logic trap_req; logic [EW-1:0] trap_entry; logic [IW-1:0] trap_src; logic trap_write;
  logic [2:0] sw_op = '0; logic [EW-1:0] sw_entry = '0;
  logic [CW-1:0] sw_data = '0; logic [IW-1:0] sw_id = '0;
  logic [EW-1:0] sw_rd_entry = '0;
  logic sw_rd_rw; logic [1:0] sw_rd_meta; logic [CW-1:0] sw_rd_ctr;
  logic [P-1:0] sw_rd_ptr_v; logic [P*IW-1:0] sw_rd_ptr_id;

  always #2 clk = ~clk;

  lp_dir_ctrl #(.NENT(NENT), .P(P), .IW(IW), .CW(CW)) u_lp_dir_ctrl (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string r, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic pkt(input int t, input int e, input int s);
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'(t); req_entry = EW'(e); req_src = IW'(s);
    @(posedge clk); #1;
    req_valid = 1'b0; req_src = '0;
  endtask

  task automatic swop(input int op, input int e, input int d, input int id);
    @(negedge clk);
    sw_op = 3'(op); sw_entry = EW'(e); sw_data = CW'(d); sw_id = IW'(id);
    @(posedge clk); #1;
    sw_op = '0;
  endtask

  task automatic peek(input int e);
    sw_rd_entry = EW'(e); #0.5;
  endtask

  task automatic rsp_is(input string r, input int v, input int kind, input int dest);
    chk({r, " rsp_valid"}, rsp_valid, v);
    if (v != 0) begin
      chk({r, " rsp_kind"}, rsp_kind, kind);
      chk({r, " rsp_dest"}, rsp_dest, dest);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    for (int e = 0; e < NENT; e++) begin
      peek(e);
      chk("R1 rw", sw_rd_rw, 0); chk("R1 meta", sw_rd_meta, 0);
      chk("R1 ctr", sw_rd_ctr, 0); chk("R1 ptr_v", sw_rd_ptr_v, 0);
    end
    chk("R1 rsp_valid", rsp_valid, 0); chk("R1 inv", inv_valid, 0); chk("R1 trap", trap_req, 0);

    // R2/R3 sweep: fill every entry, then overflow
    for (int e = 0; e < NENT; e++) begin
      for (int i = 0; i <= P; i++) begin
        pkt(0, e, 8*e + i + 1);
        peek(e);
        if (i < P) begin
          rsp_is("R2 read add", 1, 0, 8*e + i + 1);
          chk("R2 ptr_v", sw_rd_ptr_v, (1 << (i+1)) - 1);
          chk("R2 slot id", sw_rd_ptr_id[i*IW +: IW], 8*e + i + 1);
        end else begin
          rsp_is("R3 overflow", 0, 0, 0);
          chk("R3 ptr_v", sw_rd_ptr_v, (1 << P) - 1);
          chk("R3 trap", trap_req, 1); chk("R3 trap_entry", trap_entry, e);
          chk("R3 trap_src", trap_src, 8*e + i + 1); chk("R3 trap_write", trap_write, 0);
        end
      end
      pkt(0, e, 8*e + 1);
      peek(e);
      rsp_is("R2 duplicate read", 1, 0, 8*e + 1);
      chk("R2 duplicate ptr_v", sw_rd_ptr_v, (1 << P) - 1);
      pkt(0, e, 60);
      rsp_is("R12 trap pending", 1, 2, 60);
      chk("R3 trap held", trap_req, 1); chk("R3 trap_src held", trap_src, 8*e + P + 1);
      swop(4, 0, 0, 0);
      chk("R10 trap dismissed", trap_req, 0);
    end

    // R5 write to shared entry 0 by sharer 3 (slot 2)
    pkt(1, 0, 3);
    peek(0);
    chk("R5 inv_valid", inv_valid, 4'b1011);
    chk("R5 inv slot0", inv_dest[0 +: IW], 1);
    chk("R5 inv slot1", inv_dest[IW +: IW], 2);
    chk("R5 inv slot3", inv_dest[3*IW +: IW], 4);
    rsp_is("R5 no response", 0, 0, 0);
    chk("R5 ctr", sw_rd_ctr, 3); chk("R5 rw", sw_rd_rw, 1);
    chk("R5 ptr_v", sw_rd_ptr_v, 1); chk("R5 owner", sw_rd_ptr_id[0 +: IW], 3);
    pkt(0, 0, 30);
    rsp_is("R7 busy read", 1, 2, 30);
    pkt(1, 0, 31);
    rsp_is("R7 busy write", 1, 2, 31);
    peek(0); chk("R7 ctr unchanged", sw_rd_ctr, 3);
    for (int a = 0; a < 3; a++) begin
      pkt(2, 0, a == 2 ? 4 : a + 1);
      peek(0);
      chk("R6 ctr", sw_rd_ctr, 2 - a);
      if (a < 2) rsp_is("R6 ack pending", 0, 0, 0);
      else rsp_is("R6 final ack", 1, 1, 3);
    end
    pkt(2, 0, 5);
    peek(0);
    rsp_is("R6 stray ack", 0, 0, 0);
    chk("R6 stray ctr", sw_rd_ctr, 0); chk("R6 stray rw", sw_rd_rw, 1);

    // R5 owner write, R4 other writer
    pkt(1, 0, 3);
    rsp_is("R5 owner write", 1, 1, 3);
    chk("R5 owner no inv", inv_valid, 0);
    pkt(1, 0, 40);
    peek(0);
    chk("R4 inv_valid", inv_valid, 4'b0001); chk("R4 inv dest", inv_dest[0 +: IW], 3);
    rsp_is("R4 no response", 0, 0, 0);
    chk("R4 ctr", sw_rd_ctr, 1); chk("R4 owner", sw_rd_ptr_id[0 +: IW], 40);
    pkt(2, 0, 3);
    rsp_is("R4 grant", 1, 1, 40);

    // R11 read of owned block
    pkt(0, 0, 41);
    peek(0);
    chk("R11 inv_valid", inv_valid, 4'b0001); chk("R11 inv dest", inv_dest[0 +: IW], 40);
    chk("R11 ctr", sw_rd_ctr, 1);
    pkt(2, 0, 40);
    peek(0);
    rsp_is("R11 data", 1, 0, 41);
    chk("R11 rw", sw_rd_rw, 0); chk("R11 ptr_v", sw_rd_ptr_v, 1);
    chk("R11 sharer", sw_rd_ptr_id[0 +: IW], 41);

    // R8 / R9 / R10 on entry 1
    swop(3, 1, 1, 0);
    peek(1); chk("R10 meta TIP", sw_rd_meta, 1);
    pkt(0, 1, 45);
    rsp_is("R8 busy read", 1, 2, 45);
    pkt(2, 1, 9);
    rsp_is("R8 busy ack", 1, 2, 9);
    peek(1);
    chk("R8 ptr_v", sw_rd_ptr_v, 4'b1111); chk("R8 ctr", sw_rd_ctr, 0);
    swop(1, 1, 0, 0);
    peek(1); chk("R10 clear", sw_rd_ptr_v, 0);
    swop(3, 1, 2, 0);
    pkt(0, 1, 46);
    peek(1);
    rsp_is("R9 read recorded", 1, 0, 46);
    chk("R9 ptr_v", sw_rd_ptr_v, 1);
    pkt(1, 1, 47);
    rsp_is("R9 write trap", 0, 0, 0);
    chk("R9 no inv", inv_valid, 0);
    chk("R9 trap", trap_req, 1); chk("R9 trap_write", trap_write, 1);
    chk("R9 trap_entry", trap_entry, 1); chk("R9 trap_src", trap_src, 47);
    swop(2, 1, 3, 47);
    peek(1);
    chk("R10 load ctr", sw_rd_ctr, 3); chk("R10 load rw", sw_rd_rw, 1);
    chk("R10 load owner", sw_rd_ptr_id[0 +: IW], 47);
    swop(4, 0, 0, 0);
    swop(3, 1, 0, 0);
    chk("R10 trap cleared", trap_req, 0);
    for (int a = 0; a < 3; a++) begin
      pkt(2, 1, 46 - a);
      if (a < 2) rsp_is("R6 sw ack pending", 0, 0, 0);
      else rsp_is("R9 trapped write grant", 1, 1, 47);
    end

    // R5 outsider write, all four sharers invalidated
    pkt(1, 2, 50);
    peek(2);
    chk("R5 all inv", inv_valid, 4'b1111);
    for (int k = 0; k < P; k++) chk("R5 inv dest", inv_dest[k*IW +: IW], 17 + k);
    chk("R5 ctr four", sw_rd_ctr, 4);
    for (int a = 0; a < 4; a++) begin
      pkt(2, 2, 17 + a);
      if (a < 3) rsp_is("R6 pending", 0, 0, 0);
      else rsp_is("R6 grant", 1, 1, 50);
    end

    // R5 zero-sharer write, R12 conflict
    swop(1, 3, 0, 0);
    pkt(1, 3, 51);
    peek(3);
    rsp_is("R5 immediate wperm", 1, 1, 51);
    chk("R5 immediate no inv", inv_valid, 0); chk("R5 immediate ctr", sw_rd_ctr, 0);
    @(negedge clk);
    sw_op = 3'd3; sw_entry = 2'd3; sw_data = '0;
    req_valid = 1'b1; req_type = 2'd0; req_entry = 2'd3; req_src = 6'd52;
    @(posedge clk); #1;
    req_valid = 1'b0; req_src = '0; sw_op = '0;
    peek(3);
    rsp_is("R12 conflict busy", 1, 2, 52);
    chk("R12 conflict rw", sw_rd_rw, 1); chk("R12 conflict owner", sw_rd_ptr_id[0 +: IW], 51);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule